// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block connects two tri-state data buses, called A and B, and passes data both ways through separate storage banks. The forward bank captures the A bus and can drive what it holds onto B. The reverse bank captures the B bus and can drive what it holds onto A. The data path does not invert: bit i of the source bus is stored in bit i of its bank and driven onto bit i of the opposite bus.

Each direction has three active-low controls of its own: a select, a capture enable and a drive enable. The select gates both capture and drive. A direction captures only while its select and its capture enable are both low. Its bank drives the opposite bus only while its select and its drive enable are both low. In the default build the storage is a bank of flip-flops clocked by the system clock. The bank loads on every rising edge while capture is open and freezes once capture closes, so a value loaded at one edge is visible on the far bus from that edge onward. A parameter swaps in level-sensitive latches instead.

The reset input is active low. It is asserted asynchronously and released through a two-stage synchronizer. Reset clears both banks to zero.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: After reset both banks hold zero, so a direction whose select and drive enable are low drives 0x00 onto its output bus.
- R2: When fwd_sel_n and fwd_cap_n are both low at a rising clock edge, the forward bank stores the value on the A bus at that edge. This happens whatever the level of fwd_drv_n.
- R3: While fwd_cap_n is high the forward bank keeps its contents, even when the A bus changes.
- R4: While fwd_sel_n is high the forward bank keeps its contents, even when fwd_cap_n is low and the A bus changes.
- R5: The B bus is driven from the forward bank only when fwd_sel_n and fwd_drv_n are both low. Otherwise the block leaves B at high impedance.
- R6: The reverse bank follows R2 to R4 using rev_sel_n and rev_cap_n, and it captures from the B bus.
- R7: The A bus is driven from the reverse bank only when rev_sel_n and rev_drv_n are both low. Otherwise the block leaves A at high impedance.
- R8: The path does not invert: bit i of the captured bus appears unchanged on bit i of the opposite bus.
- R9: The two directions are independent. When both banks capture in the same cycle while both drive, each bank takes the other's old contents and the two values swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the banks |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| fwd_sel_n | input | 1 | Forward (A to B) select, active low |
| fwd_cap_n | input | 1 | Forward capture enable, active low |
| fwd_drv_n | input | 1 | Forward drive enable onto B, active low |
| rev_sel_n | input | 1 | Reverse (B to A) select, active low |
| rev_cap_n | input | 1 | Reverse capture enable, active low |
| rev_drv_n | input | 1 | Reverse drive enable onto A, active low |
| a_bus | inout | WIDTH | Bus A: source of the forward bank, driven by the reverse bank |
| b_bus | inout | WIDTH | Bus B: source of the reverse bank, driven by the forward bank |

## Verification
One bank can capture a bus in the same cycle that the other bank is driving that same bus. The clearest case is both directions capturing while both drive, which makes the two banks exchange their contents. Directed steps set this up on purpose, and random control patterns reach it again many times. A bench model predicts the value seen on each bus in every cycle: the block's own drive, the bench's drive, or the pull-up level when nothing drives. The bench only drives a bus when the model says the block does not. Each bus is compared against the prediction before every clock edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Active-low control set of one direction.
  typedef struct packed {
    logic sel_n;
    logic cap_n;
    logic drv_n;
  } xcvr_ctrl_t;

  // Decoded, active-high intents of one direction.
  typedef struct packed {
    logic load;
    logic drive;
  } xcvr_dec_t;

  localparam int unsigned DIR_FWD = 0;
  localparam int unsigned DIR_REV = 1;
  localparam int unsigned NUM_DIR = 2;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/xcvr_ctrl_dec.sv
module xcvr_ctrl_dec
  import xcvr_pkg::*;
(
  input  xcvr_ctrl_t ctrl_i,
  output xcvr_dec_t  dec_o
);

  // The select gates both capture and drive; raising either
  // select or capture enable closes the bank.
  logic hold;

  always_comb begin
    hold        = ctrl_i.sel_n | ctrl_i.cap_n;
    dec_o.load  = ~hold;
    dec_o.drive = ~(ctrl_i.sel_n | ctrl_i.drv_n);
  end

endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          CLOCKED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] store_q;

  generate
    if (CLOCKED) begin : g_flop
      logic [WIDTH-1:0] store_d;

      always_comb begin
        store_d = store_q;
        if (load_i) begin
          store_d = d_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          store_q <= '0;
        end else begin
          store_q <= store_d;
        end
      end
    end else begin : g_latch
      logic unused_clk;
      assign unused_clk = clk;

      always_latch begin
        if (!rst_n) begin
          store_q <= '0;
        end else if (load_i) begin
          store_q <= d_i;
        end
      end
    end
  endgenerate

  assign q_o = store_q;

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter bit          CLOCKED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd_sel_n,
  input  logic             fwd_cap_n,
  input  logic             fwd_drv_n,
  input  logic             rev_sel_n,
  input  logic             rev_cap_n,
  input  logic             rev_drv_n,
  inout  wire  [WIDTH-1:0] a_bus,
  inout  wire  [WIDTH-1:0] b_bus
);

  logic rst_sync_n;

  xcvr_ctrl_t [NUM_DIR-1:0]            ctrl_w;
  xcvr_dec_t  [NUM_DIR-1:0]            dec_w;
  logic       [NUM_DIR-1:0][WIDTH-1:0] src_w;
  logic       [NUM_DIR-1:0][WIDTH-1:0] q_w;
  logic       [NUM_DIR-1:0]            drv_w;

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctrl_w[DIR_FWD] = '{sel_n: fwd_sel_n, cap_n: fwd_cap_n, drv_n: fwd_drv_n};
    ctrl_w[DIR_REV] = '{sel_n: rev_sel_n, cap_n: rev_cap_n, drv_n: rev_drv_n};
    src_w[DIR_FWD]  = a_bus;
    src_w[DIR_REV]  = b_bus;
  end

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      xcvr_ctrl_dec u_dec (
        .ctrl_i (ctrl_w[d]),
        .dec_o  (dec_w[d])
      );

      xcvr_bank #(.WIDTH(WIDTH), .CLOCKED(CLOCKED)) u_bank (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .load_i (dec_w[d].load),
        .d_i    (src_w[d]),
        .q_o    (q_w[d])
      );

      assign drv_w[d] = dec_w[d].drive;
    end
  endgenerate

  assign b_bus = drv_w[DIR_FWD] ? q_w[DIR_FWD] : {WIDTH{1'bz}};
  assign a_bus = drv_w[DIR_REV] ? q_w[DIR_REV] : {WIDTH{1'bz}};

endmodule

// File: rtl/bidir_latch_xcvr_chk.sv
module bidir_latch_xcvr_chk #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          CLOCKED = 1'b1
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             fwd_sel_n,
  input logic             fwd_cap_n,
  input logic             fwd_drv_n,
  input logic             rev_sel_n,
  input logic             rev_cap_n,
  input logic             rev_drv_n,
  input logic [WIDTH-1:0] a_bus,
  input logic [WIDTH-1:0] b_bus,
  input logic [WIDTH-1:0] q_fwd,
  input logic [WIDTH-1:0] q_rev,
  input logic             drv_fwd,
  input logic             drv_rev
);

  generate
    if (CLOCKED) begin : g_clk_props
      // R2: open forward capture stores the A bus at the edge
      a_r2_fwd_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (!fwd_sel_n && !fwd_cap_n) |=> (q_fwd == $past(a_bus)));

      // R3: closed capture enable freezes the forward bank
      a_r3_fwd_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
        fwd_cap_n |=> $stable(q_fwd));

      // R4: raised select freezes the forward bank
      a_r4_fwd_sel_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
        fwd_sel_n |=> $stable(q_fwd));

      // R6: reverse bank loads from B and holds when closed
      a_r6_rev_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (!rev_sel_n && !rev_cap_n) |=> (q_rev == $past(b_bus)));

      a_r6_rev_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (rev_sel_n || rev_cap_n) |=> $stable(q_rev));
    end
  endgenerate

  // R5: B is released unless forward select and drive are both low
  a_r5_b_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fwd_sel_n || fwd_drv_n) |-> !drv_fwd);

  // R7: A is released unless reverse select and drive are both low
  a_r7_a_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rev_sel_n || rev_drv_n) |-> !drv_rev);

endmodule

bind bidir_latch_xcvr bidir_latch_xcvr_chk #(.WIDTH(WIDTH), .CLOCKED(CLOCKED)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .fwd_sel_n  (fwd_sel_n),
  .fwd_cap_n  (fwd_cap_n),
  .fwd_drv_n  (fwd_drv_n),
  .rev_sel_n  (rev_sel_n),
  .rev_cap_n  (rev_cap_n),
  .rev_drv_n  (rev_drv_n),
  .a_bus      (a_bus),
  .b_bus      (b_bus),
  .q_fwd      (q_w[0]),
  .q_rev      (q_w[1]),
  .drv_fwd    (drv_w[0]),
  .drv_rev    (drv_w[1])
);

// File: tb/bidir_latch_xcvr_tb_top.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_tb_top;

  localparam int unsigned W = 8;
  typedef logic [W-1:0] word_t;

  logic clk;
  logic rst_n;
  logic fwd_sel_n, fwd_cap_n, fwd_drv_n;
  logic rev_sel_n, rev_cap_n, rev_drv_n;
  word_t tb_a, tb_b;
  logic  tb_a_en, tb_b_en;

  tri1 [W-1:0] a_bus;
  tri1 [W-1:0] b_bus;

  assign a_bus = tb_a_en ? tb_a : {W{1'bz}};
  assign b_bus = tb_b_en ? tb_b : {W{1'bz}};

  bidir_latch_xcvr #(.WIDTH(W), .CLOCKED(1'b1)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_sel_n (fwd_sel_n),
    .fwd_cap_n (fwd_cap_n),
    .fwd_drv_n (fwd_drv_n),
    .rev_sel_n (rev_sel_n),
    .rev_cap_n (rev_cap_n),
    .rev_drv_n (rev_drv_n),
    .a_bus     (a_bus),
    .b_bus     (b_bus)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int unsigned n_vec;
  int unsigned n_bad;
  word_t m_fwd, m_rev;

  // Expected bus value: block drive, else bench drive, else pull-up.
  function automatic word_t bus_exp(input logic dut_on, input word_t dut_v,
                                    input logic tb_on, input word_t tb_v);
    if (dut_on) return dut_v;
    if (tb_on)  return tb_v;
    return '1;
  endfunction

  task automatic check(input string tag, input word_t act, input word_t exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // c = {fwd_sel_n, fwd_cap_n, fwd_drv_n, rev_sel_n, rev_cap_n, rev_drv_n}
  task automatic step(input logic [5:0] c, input word_t av, input word_t bv,
                      input logic want_a, input logic want_b,
                      input string tag_b, input string tag_a);
    logic  dut_b, dut_a, ld_f, ld_r;
    word_t a_seen, b_seen;
    @(negedge clk);
    {fwd_sel_n, fwd_cap_n, fwd_drv_n, rev_sel_n, rev_cap_n, rev_drv_n} = c;
    dut_b   = !c[5] && !c[3];
    dut_a   = !c[2] && !c[0];
    tb_a_en = want_a && !dut_a;
    tb_b_en = want_b && !dut_b;
    tb_a    = av;
    tb_b    = bv;
    #1;
    if ((tb_a_en && dut_a) || (tb_b_en && dut_b)) begin
      n_bad++;
      $display("FAIL R5/R7 contention: actual 1 expected 0");
    end
    b_seen = bus_exp(dut_b, m_fwd, tb_b_en, bv);
    a_seen = bus_exp(dut_a, m_rev, tb_a_en, av);
    check(tag_b, b_bus, b_seen);
    check(tag_a, a_bus, a_seen);
    ld_f = !c[5] && !c[4];
    ld_r = !c[2] && !c[1];
    @(posedge clk);
    if (ld_f) m_fwd = a_seen;
    if (ld_r) m_rev = b_seen;
  endtask

  localparam logic [5:0] IDLE     = 6'b111_111;
  localparam logic [5:0] SHOW_ALL = 6'b010_010;

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    m_fwd = '0; m_rev = '0;
    rst_n = 1'b0;
    {fwd_sel_n, fwd_cap_n, fwd_drv_n, rev_sel_n, rev_cap_n, rev_drv_n} = IDLE;
    tb_a = '0; tb_b = '0; tb_a_en = 1'b0; tb_b_en = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: both banks cleared, both directions driving
    step(SHOW_ALL, '0, '0, 0, 0, "R1", "R1");

    // R2: forward capture with drive off, then reveal on B
    step(6'b001_111, 8'hA5, 8'h00, 1, 1, "R5", "R7");
    step(6'b010_111, 8'h00, 8'h00, 1, 1, "R2", "R7");
    // R3: capture enable high, A changes
    step(6'b011_111, 8'h3C, 8'h00, 1, 1, "R3", "R7");
    step(6'b010_111, 8'h3C, 8'h00, 1, 1, "R3", "R7");
    // R4: select high with capture low, A changes
    step(6'b101_111, 8'h66, 8'h00, 1, 1, "R4", "R7");
    step(6'b010_111, 8'h66, 8'h00, 1, 1, "R4", "R7");

    // R8: single-bit patterns keep their position
    step(6'b001_111, 8'h01, 8'h00, 1, 1, "R5", "R7");
    step(6'b010_111, 8'h00, 8'h00, 1, 1, "R8", "R7");
    step(6'b001_111, 8'h80, 8'h00, 1, 1, "R5", "R7");
    step(6'b010_111, 8'h00, 8'h00, 1, 1, "R8", "R7");

    // R6: reverse capture from B and hold
    step(6'b111_001, 8'h00, 8'h5A, 1, 1, "R5", "R7");
    step(6'b111_010, 8'h00, 8'h00, 1, 1, "R5", "R6");
    step(6'b111_011, 8'h00, 8'hF0, 1, 1, "R5", "R6");
    step(6'b111_101, 8'h00, 8'h0F, 1, 1, "R5", "R6");
    step(6'b111_010, 8'h00, 8'h00, 1, 1, "R5", "R6");

    // R9: both capture while both drive: contents swap
    step(6'b000_000, 8'h00, 8'h00, 1, 1, "R9", "R9");
    step(SHOW_ALL, 8'h00, 8'h00, 1, 1, "R9", "R9");

    // R5/R7: floating buses with nothing driving
    step(IDLE, 8'h00, 8'h00, 0, 0, "R5", "R7");

    // Random control and data mix, R5/R7 checked every cycle
    for (int i = 0; i < 600; i++) begin
      step(6'($urandom), word_t'($urandom), word_t'($urandom),
           1'($urandom), 1'($urandom), "R5", "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule